// File: doc/BRIEF.md
# Symmetric FIR Paired-Tap Address Generator

This block produces the read offsets into a circular sample buffer for a linear-phase FIR filter. The filter has an even number N of symmetric taps. For each output sample, the taps that share one coefficient are fetched on back-to-back cycles. The order is the newest sample, then the oldest, then the second newest, then the second oldest, and so on inward. A pre-adder downstream can then sum each mirrored pair before a single multiply.

One offset is issued on each clock in which `en` is high. A step counter runs from 0 to N-1. From it the block takes a step distance S = (N-1) - count. The step is subtracted modulo N on even counts and added on odd counts. On the final count the step is replaced by a jump, which lands on the newest sample of the next output. That sample sits one slot after the previous newest sample. The tap count N is an input, so one instance can serve any even filter length up to a build-time maximum.

The control is a three-state machine that tracks the kind of step taken from the current fetch:
- `PH_SUB` is the subtract step on even counts. It goes to `PH_ADD`, or to `PH_WRAP` when the next count is N-1.
- `PH_ADD` is the add step on odd, non-final counts. It always goes to `PH_SUB`.
- `PH_WRAP` is the final-count jump. It always goes to `PH_SUB`, and the count restarts at 0.

Reset enters `PH_SUB`. No state changes while `en` is low.

Top module: `fir_pair_addr_gen`

## Requirements
- R1: While `rst_n` is low and just after it is released, `offset` is 0 and `done` is 0.
- R2: With base offset b = j mod N for output number j (counting from 0 after reset), fetch k of that output (k in 0..N-1) reads (b - d) mod N. Here d = k/2 when k is even, and d = N-1-(k-1)/2 when k is odd.
- R3: On an even count c, the next offset is (current - (N-1-c)) mod N.
- R4: On an odd count c below N-1, the next offset is (current + (N-1-c)) mod N.
- R5: On count N-1, the next offset is current-(N/2-1) when current >= N/2, otherwise (current+N/2+1) mod N; it equals (b+1) mod N.
- R6: `done` is 1 exactly in the cycle where `en` is 1 and the last fetch (k = N-1) of an output is presented; the following fetch is k = 0.
- R7: While `en` is 0, `offset` and the fetch position hold and `done` is 0.
- R8: `offset` is always below N.
- R9: Every even N from 2 to MAX_N is supported; N may change only while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance to the next fetch at this edge |
| n_taps | input | $clog2(MAX_N)+1 | Tap count N, even, 2..MAX_N |
| offset | output | $clog2(MAX_N) | Circular-buffer offset of the current fetch |
| done | output | 1 | Current fetch is the last of this output sample |

## Verification
The bench builds the block with MAX_N = 16 and runs it for N = 2, 4, 8 and 16. For each N it covers more than N output samples. That is enough for the base offset to travel once around the whole buffer and return to zero, so every final-count jump, including the one that lands back on 0, is reached. A fixed pattern of idle cycles is mixed in so that holds fall in every state. N = 2 reaches the case where the jump is zero and `PH_SUB` goes straight to `PH_WRAP`.

// File: rtl/fir_pair_pkg.sv
package fir_pair_pkg;

    // Kind of step applied to the offset leaving the current fetch
    typedef enum logic [1:0] {
        PH_SUB  = 2'd0,
        PH_ADD  = 2'd1,
        PH_WRAP = 2'd2
    } phase_e;

endpackage

// File: rtl/fir_pair_seq.sv
module fir_pair_seq
    import fir_pair_pkg::*;
#(
    parameter int MAX_N = 16,
    localparam int AW = $clog2(MAX_N),
    localparam int NW = AW + 1,
    localparam int EW = NW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NW-1:0] n_taps,
    output logic [AW-1:0] cnt,
    output phase_e        phase
);

    phase_e        state_q, state_d;
    logic [AW-1:0] cnt_q, cnt_d;
    logic [EW-1:0] next_cnt_w;
    logic [EW-1:0] last_w;

    assign next_cnt_w = EW'(cnt_q) + EW'(1);
    assign last_w     = EW'(n_taps) - EW'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_SUB;
            cnt_q   <= '0;
        end else if (en) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PH_SUB: begin
                cnt_d   = next_cnt_w[AW-1:0];
                state_d = (next_cnt_w == last_w) ? PH_WRAP : PH_ADD;
            end
            PH_ADD: begin
                cnt_d   = next_cnt_w[AW-1:0];
                state_d = PH_SUB;
            end
            PH_WRAP: begin
                cnt_d   = '0;
                state_d = PH_SUB;
            end
            default: begin
                cnt_d   = '0;
                state_d = PH_SUB;
            end
        endcase
    end

    // outputs
    always_comb begin
        cnt   = cnt_q;
        phase = state_q;
    end

    // R8: count stays inside the tap range
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        EW'(cnt_q) < EW'(n_taps));

    // R5: the jump state coincides with the final count
    a_r5_wrap_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_WRAP) == (EW'(cnt_q) == last_w));

    // R3: subtract steps sit on even counts
    a_r3_sub_even: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SUB) |-> (cnt_q[0] == 1'b0));

endmodule

// File: rtl/fir_pair_next.sv
module fir_pair_next
    import fir_pair_pkg::*;
#(
    parameter int MAX_N = 16,
    localparam int AW = $clog2(MAX_N),
    localparam int NW = AW + 1,
    localparam int EW = NW + 1
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] cnt,
    input  logic [NW-1:0] n_taps,
    input  phase_e        phase,
    output logic [AW-1:0] nxt
);

    logic [EW-1:0] n_w, o_w, step_w, half_w, raw_w, red_w;

    always_comb begin
        n_w    = EW'(n_taps);
        o_w    = EW'(cur);
        step_w = n_w - EW'(1) - EW'(cnt);
        half_w = n_w >> 1;
        raw_w  = o_w;
        unique case (phase)
            PH_SUB:  raw_w = (o_w >= step_w) ? (o_w - step_w) : (o_w + n_w - step_w);
            PH_ADD:  raw_w = o_w + step_w;
            PH_WRAP: raw_w = (o_w >= half_w) ? (o_w - (half_w - EW'(1)))
                                             : (o_w + half_w + EW'(1));
            default: raw_w = o_w;
        endcase
        red_w = (raw_w >= n_w) ? (raw_w - n_w) : raw_w;
        nxt   = red_w[AW-1:0];
    end

endmodule

// File: rtl/fir_pair_addr_gen.sv
module fir_pair_addr_gen
    import fir_pair_pkg::*;
#(
    parameter int MAX_N = 16,
    localparam int AW = $clog2(MAX_N),
    localparam int NW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NW-1:0] n_taps,
    output logic [AW-1:0] offset,
    output logic          done
);

    logic [AW-1:0] cnt;
    phase_e        phase;
    logic [AW-1:0] off_q, off_d;

    fir_pair_seq #(.MAX_N(MAX_N)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .n_taps (n_taps),
        .cnt    (cnt),
        .phase  (phase)
    );

    fir_pair_next #(.MAX_N(MAX_N)) u_next (
        .cur    (off_q),
        .cnt    (cnt),
        .n_taps (n_taps),
        .phase  (phase),
        .nxt    (off_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else if (en) off_q <= off_d;
    end

    always_comb begin
        offset = off_q;
        done   = en && (phase == PH_WRAP);
    end

    // R8: offset inside the buffer
    a_r8_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        (NW'(off_q) < n_taps));

    // R7: idle cycles change nothing
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(off_q) && $stable(cnt)));

    // R6: a completed output restarts the count
    a_r6_done_restart: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt == '0));

    // R3: a subtract step always moves the offset
    a_r3_sub_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == PH_SUB) |=> (off_q != $past(off_q)));

endmodule

// File: tb/sim_fir_pair_addr_gen.sv
`timescale 1ns/1ps
module sim_fir_pair_addr_gen;

    localparam int MAX_N = 16;
    localparam int AW = $clog2(MAX_N);
    localparam int NW = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [NW-1:0] n_taps = NW'(4);
    logic [AW-1:0] offset;
    logic          done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fir_pair_addr_gen #(.MAX_N(MAX_N)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .n_taps(n_taps),
        .offset(offset), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_off(input int n, input int idx);
        int j = idx / n;
        int k = idx % n;
        int b = j % n;
        int d = (k % 2 == 0) ? k / 2 : n - 1 - (k - 1) / 2;
        return (b + n - d) % n;
    endfunction

    task automatic run_n(input int n);
        int idx = 0;
        int cyc = 0;
        @(negedge clk);
        rst_n  = 1'b0;
        en     = 1'b0;
        n_taps = NW'(n);
        #1;
        check("R1 offset in reset", int'(offset), 0);
        check("R1 done in reset", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 offset after reset", int'(offset), 0);
        while (idx < (n + 2) * n) begin
            @(negedge clk);
            en = ((cyc % 7) != 3) && ((cyc % 11) != 5);
            #1;
            // R2 R3 R4 R5 R7 R8 R9: offset follows the paired order, holds when idle
            check(en ? "R2/R9 offset order" : "R7 offset hold", int'(offset), exp_off(n, idx));
            check(en ? "R6 done flag" : "R7 done low", int'(done),
                  (en && (idx % n) == n - 1) ? 1 : 0);
            n_checks++;
            if (int'(offset) >= n) begin
                n_fail++;
                $display("FAIL R8 actual=%0d expected below %0d", offset, n);
            end
            @(posedge clk);
            if (en) idx++;
            cyc++;
        end
        @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        run_n(2);
        run_n(4);
        run_n(8);
        run_n(16);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule